// File: doc/BRIEF.md
# Modified Euclidean Key-Equation Solver

This block finds the error locator σ(x) and error evaluator ω(x) of a Reed-Solomon decoder over GF(2^8). It accepts the 2T syndrome coefficients from an upstream syndrome stage and solves S(x)·σ(x) ≡ ω(x) mod x^(2T). The method is a division-free Euclid iteration over four coefficient registers: a remainder R, a partner remainder Q, a multiplier L and a partner multiplier U. Each step cross-multiplies each polynomial by the leading coefficient of the other one, so that the top term cancels. When the degree order of R and Q is reversed, the two pairs trade places. All 2T+1 coefficient positions update together, one iteration per clock.

The block is controlled by a four-state machine. IDLE waits for `start`. LOAD collects syndromes, and the final syndrome beat moves it to SOLVE. SOLVE runs iterations. When the remainder degree falls below T, or when the iteration budget is used up, it moves to EMIT. EMIT streams T+1 coefficient pairs and returns to IDLE after the last one. A `start` pulse in any state moves the machine to LOAD and reinitialises the registers. The field uses the primitive polynomial x^8+x^4+x^3+x^2+1, and α = 0x02.

Top module: `keyeq_solver`

## Requirements
- R1: After reset, out_valid, out_done and out_err are all 0.
- R2: A `start` pulse opens a load. The next 2T cycles with syn_valid high store S_0 first, up to S_(2T-1) last. Cycles with syn_valid low are ignored, whatever syn_data carries.
- R3: The registers start as R = x^(2T), Q = S(x), L = 0 and U = 1. Let a be the leading coefficient of R and b that of Q, and let d = deg R − deg Q. When d ≥ 0, one iteration sets R ← b·R + a·x^d·Q and L ← b·L + a·x^d·U, and leaves Q and U unchanged.
- R4: When deg R < deg Q, with e = deg Q − deg R, one iteration sets R ← a·Q + b·x^e·R and L ← a·U + b·x^e·L. It also sets Q ← old R and U ← old L.
- R5: Iterations run one per clock, starting on the first edge after the final syndrome beat. When n iterations are made, the first output beat is visible after the (n+1)-th edge that follows the final syndrome beat.
- R6: The output is T+1 consecutive beats with out_valid high. Beat k (k = 0..T) carries out_sigma = L_k and out_omega = R_k. out_done is high on beat T only.
- R7: With at most T symbol errors, σ has degree equal to the error count and is zero at α^(−p) for each error position p. The key equation S·σ ≡ ω mod x^(2T) also holds for the emitted coefficients.
- R8: When all syndromes are zero, one extra SOLVE cycle is spent (n = 1). The block then emits σ = 1 (σ_0 = 0x01, all other coefficients 0), ω = 0 and out_err = 0.
- R9: At most MAX_ITER iterations are made. If deg R ≥ T after that many, out_err is 1 on every output beat; otherwise it is 0.
- R10: A `start` pulse during a load discards the partial load and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new syndrome load |
| syn_valid | input | 1 | syn_data carries a syndrome this cycle |
| syn_data | input | 8 | Syndrome coefficient, lowest index first |
| out_valid | output | 1 | An output coefficient pair is present |
| out_sigma | output | 8 | Error-locator coefficient of the current beat |
| out_omega | output | 8 | Error-evaluator coefficient of the current beat |
| out_done | output | 1 | Marks the final output beat |
| out_err | output | 1 | The iteration budget ran out before convergence |

## Verification
The bench counts the iterations n that its behavioural model needs for each syndrome set. The block's first output beat is due n+1 edges after the final syndrome beat, and the remaining T beats follow on consecutive edges. On every falling edge from the final syndrome beat onward, the bench compares out_valid, the coefficients, out_done and out_err with the model's prediction for that cycle. A second instance with a budget of two iterations gets the same stimulus, so that the early-exit path and its error flag are timed the same way. After the stream ends, the captured σ and ω are also checked against the injected error positions and the key equation.

// File: rtl/keyeq_pkg.sv
package keyeq_pkg;
    localparam int SYM_W = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SOLVE, ST_EMIT} state_t;

    // carry-less shift-and-add product reduced by the field polynomial
    function automatic sym_t gf_mul(sym_t x, sym_t y);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = x;
        for (int i = 0; i < SYM_W; i++) begin
            if (y[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction
endpackage

// File: rtl/keyeq_deg.sv
module keyeq_deg #(
    parameter int NC  = 17,
    parameter int DGW = 6
) (
    input  logic [NC-1:0][keyeq_pkg::SYM_W-1:0] poly,
    output logic signed [DGW-1:0]               deg,
    output logic [keyeq_pkg::SYM_W-1:0]         lead
);
    // highest nonzero position; all ones (-1) for the zero polynomial
    always_comb begin
        deg  = '1;
        lead = '0;
        for (int j = 0; j < NC; j++) begin
            if (poly[j] != '0) begin
                deg  = DGW'(j);
                lead = poly[j];
            end
        end
    end
endmodule

// File: rtl/keyeq_cell.sv
module keyeq_cell
    import keyeq_pkg::*;
(
    input  sym_t x_c,
    input  sym_t y_c,
    input  sym_t xl_c,
    input  sym_t yl_c,
    input  sym_t lead_x,
    input  sym_t lead_y,
    output sym_t r_nx,
    output sym_t l_nx
);
    // four products, two sums per coefficient position
    assign r_nx = gf_mul(lead_y, x_c)  ^ gf_mul(lead_x, y_c);
    assign l_nx = gf_mul(lead_y, xl_c) ^ gf_mul(lead_x, yl_c);
endmodule

// File: rtl/keyeq_solver.sv
module keyeq_solver
    import keyeq_pkg::*;
#(
    parameter int T        = 8,
    parameter int MAX_ITER = 2 * T
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             syn_valid,
    input  logic [SYM_W-1:0] syn_data,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sigma,
    output logic [SYM_W-1:0] out_omega,
    output logic             out_done,
    output logic             out_err
);
    localparam int NC  = 2 * T + 1;
    localparam int PW  = NC * SYM_W;
    localparam int IXW = $clog2(NC);
    localparam int DGW = $clog2(NC) + 1;
    localparam int CW  = $clog2(MAX_ITER + 1);
    localparam logic [PW-1:0] R_INIT = PW'(1) << ((NC - 1) * SYM_W);
    localparam logic [PW-1:0] U_INIT = PW'(1);
    localparam logic signed [DGW-1:0] T_DEG = DGW'(T);
    localparam logic [IXW-1:0] LAST_IX  = IXW'(2 * T - 1);
    localparam logic [IXW-1:0] LAST_K   = IXW'(T);
    localparam logic [CW-1:0]  ITER_CAP = CW'(MAX_ITER);

    state_t state, nxt;
    logic [NC-1:0][SYM_W-1:0] r_q, q_q, l_q, u_q;
    logic [NC-1:0][SYM_W-1:0] x_p, y_p, xl_p, yl_p, ysh, ylsh, r_nx, l_nx;
    logic [IXW-1:0] idx_q, k_q;
    logic [CW-1:0]  it_cnt;
    logic           err_q;
    logic signed [DGW-1:0] dr, dq;
    logic [DGW-1:0] shamt;
    sym_t a_lead, b_lead, lx, ly;
    logic swap, stop_hit, cap_hit, q_zero, iterate;

    keyeq_deg #(.NC(NC), .DGW(DGW)) u_deg_r (.poly(r_q), .deg(dr), .lead(a_lead));
    keyeq_deg #(.NC(NC), .DGW(DGW)) u_deg_q (.poly(q_q), .deg(dq), .lead(b_lead));

    assign swap     = (dr < dq);
    assign shamt    = swap ? DGW'(dq - dr) : DGW'(dr - dq);
    assign stop_hit = (dr < T_DEG);
    assign cap_hit  = (it_cnt == ITER_CAP);
    assign q_zero   = dq[DGW-1];
    assign iterate  = (state == ST_SOLVE) && !start && !stop_hit && !cap_hit && !q_zero;

    // the unshifted operand is the higher-degree pair's partner after any swap
    assign x_p  = swap ? q_q : r_q;
    assign y_p  = swap ? r_q : q_q;
    assign xl_p = swap ? u_q : l_q;
    assign yl_p = swap ? l_q : u_q;
    assign lx   = swap ? b_lead : a_lead;
    assign ly   = swap ? a_lead : b_lead;

    always_comb begin
        for (int j = 0; j < NC; j++) begin
            ysh[j]  = '0;
            ylsh[j] = '0;
        end
        for (int i = 0; i < NC; i++) begin
            for (int j = 0; j < NC; j++) begin
                if (j == i + int'(shamt)) begin
                    ysh[j]  = y_p[i];
                    ylsh[j] = yl_p[i];
                end
            end
        end
    end

    for (genvar j = 0; j < NC; j++) begin : g_pos
        keyeq_cell u_cell (
            .x_c   (x_p[j]),
            .y_c   (ysh[j]),
            .xl_c  (xl_p[j]),
            .yl_c  (ylsh[j]),
            .lead_x(lx),
            .lead_y(ly),
            .r_nx  (r_nx[j]),
            .l_nx  (l_nx[j])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_LOAD;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_LOAD:  if (syn_valid && idx_q == LAST_IX) nxt = ST_SOLVE;
                ST_SOLVE: if (stop_hit || cap_hit) nxt = ST_EMIT;
                ST_EMIT:  if (k_q == LAST_K) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // polynomial registers and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0; q_q <= '0; l_q <= '0; u_q <= '0;
            idx_q <= '0; k_q <= '0; it_cnt <= '0; err_q <= 1'b0;
        end else if (start) begin
            r_q <= R_INIT; q_q <= '0; l_q <= '0; u_q <= U_INIT;
            idx_q <= '0; k_q <= '0; it_cnt <= '0; err_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_LOAD: begin
                    if (syn_valid) begin
                        q_q[idx_q] <= syn_data;
                        idx_q      <= idx_q + IXW'(1);
                    end
                end
                ST_SOLVE: begin
                    if (stop_hit) begin
                        k_q <= '0;
                    end else if (cap_hit) begin
                        err_q <= 1'b1;
                        k_q   <= '0;
                    end else if (q_zero) begin
                        r_q <= '0;
                        l_q <= U_INIT;
                    end else begin
                        r_q <= r_nx;
                        l_q <= l_nx;
                        if (swap) begin
                            q_q <= r_q;
                            u_q <= l_q;
                        end
                        it_cnt <= it_cnt + CW'(1);
                    end
                end
                ST_EMIT: if (k_q != LAST_K) k_q <= k_q + IXW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        out_valid = (state == ST_EMIT);
        out_done  = out_valid && (k_q == LAST_K);
        out_sigma = out_valid ? l_q[k_q] : '0;
        out_omega = out_valid ? r_q[k_q] : '0;
        out_err   = err_q;
    end

    // R3
    degree_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iterate && !swap) |=> (dr < $past(dr)));
    // R4
    swap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iterate && swap) |=> ((dr < $past(dq)) && (dq == $past(dr))));
    // R5
    stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (dr < T_DEG));
    // R9
    err_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (dr >= T_DEG));
    // R9
    iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        it_cnt <= ITER_CAP);
    // R6
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(out_done) || $past(start)));
endmodule

// File: tb/keyeq_solver_test.sv
module keyeq_solver_test;
    localparam int T = 8, NC = 2 * T + 1, NS = 2 * T, N = 255, LIMIT = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, syn_valid = 1'b0;
    logic [7:0] syn_data = 8'h00;
    logic ov_a, dn_a, er_a, ov_b, dn_b, er_b;
    logic [7:0] sg_a, om_a, sg_b, om_b;

    keyeq_solver #(.T(T)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .syn_valid(syn_valid), .syn_data(syn_data),
        .out_valid(ov_a), .out_sigma(sg_a), .out_omega(om_a), .out_done(dn_a), .out_err(er_a));
    keyeq_solver #(.T(T), .MAX_ITER(LIMIT)) uut_lim (
        .clk(clk), .rst_n(rst_n), .start(start), .syn_valid(syn_valid), .syn_data(syn_data),
        .out_valid(ov_b), .out_sigma(sg_b), .out_omega(om_b), .out_done(dn_b), .out_err(er_b));

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    int exp_t[512];
    int log_t[256];
    int syn[NS];
    int gen[NC];
    int word[N];
    int sa[NC], oa[NC], sb[NC], ob[NC];
    int na, nb;
    bit ea, eb;
    int cap_s[NC], cap_o[NC];
    int errpos[T];
    bit lim_err_seen = 1'b0;

    function automatic int gmul(input int x, input int y);
        if (x == 0 || y == 0) return 0;
        return exp_t[log_t[x] + log_t[y]];
    endfunction

    function automatic int pdeg(input int p[NC]);
        int d = -1;
        for (int j = 0; j < NC; j++) if (p[j] != 0) d = j;
        return d;
    endfunction

    function automatic int peval(input int p[NC], input int x);
        int acc = 0;
        for (int j = NC - 1; j >= 0; j--) acc = gmul(acc, x) ^ p[j];
        return acc;
    endfunction

    task automatic build_tables();
        int v = 1;
        log_t[0] = 0;
        for (int i = 0; i < 512; i++) begin
            exp_t[i] = v;
            if (i < 255) log_t[v] = i;
            v = v << 1;
            if ((v & 256) != 0) v = v ^ 'h11D;
        end
    endtask

    task automatic make_gen();
        for (int j = 0; j < NC; j++) gen[j] = 0;
        gen[0] = 1;
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j >= 1; j--) gen[j] = gen[j-1] ^ gmul(gen[j], exp_t[i]);
            gen[0] = gmul(gen[0], exp_t[i]);
        end
    endtask

    // behavioural solver: iteration count, error flag, final L and R
    task automatic mea(input int maxit, output int n, output bit e, output int so[NC], output int oo[NC]);
        int r[NC], q[NC], l[NC], u[NC], nr[NC], nl[NC];
        int dr, dq, a, b, sh;
        bit zero;
        zero = 1'b1;
        for (int j = 0; j < NC; j++) begin r[j] = 0; q[j] = 0; l[j] = 0; u[j] = 0; end
        r[NS] = 1; u[0] = 1;
        for (int i = 0; i < NS; i++) begin q[i] = syn[i]; if (syn[i] != 0) zero = 1'b0; end
        n = 0;
        if (zero) begin
            r[NS] = 0; l[0] = 1; n = 1;
        end else begin
            while (pdeg(r) >= T && n < maxit) begin
                dr = pdeg(r); dq = pdeg(q); a = r[dr]; b = q[dq];
                if (dr >= dq) begin
                    sh = dr - dq;
                    for (int j = 0; j < NC; j++) begin
                        nr[j] = gmul(b, r[j]); nl[j] = gmul(b, l[j]);
                        if (j >= sh) begin nr[j] ^= gmul(a, q[j-sh]); nl[j] ^= gmul(a, u[j-sh]); end
                    end
                end else begin
                    sh = dq - dr;
                    for (int j = 0; j < NC; j++) begin
                        nr[j] = gmul(a, q[j]); nl[j] = gmul(a, u[j]);
                        if (j >= sh) begin nr[j] ^= gmul(b, r[j-sh]); nl[j] ^= gmul(b, l[j-sh]); end
                    end
                    q = r; u = l;
                end
                r = nr; l = nl;
                n++;
            end
        end
        e = (pdeg(r) >= T);
        so = l; oo = r;
    endtask

    task automatic cmp(input string who, input string rq, input logic v, input logic [7:0] sg,
                       input logic [7:0] om, input logic dn, input logic er, input int c,
                       input int n, input bit e, input int es[NC], input int eo[NC]);
        bit ev;
        int k;
        ev = (c >= n + 1) && (c <= n + 1 + T);
        k = c - n - 1;
        checks++;
        if (v !== ev) begin
            failures++;
            $display("FAIL R5 %s %s cycle %0d out_valid=%0b expected %0b", rq, who, c, v, ev);
        end else if (ev && (sg !== 8'(es[k]) || om !== 8'(eo[k]))) begin
            failures++;
            $display("FAIL R3 R4 %s %s beat %0d sigma=%h omega=%h expected %h %h", rq, who, k, sg, om, 8'(es[k]), 8'(eo[k]));
        end else if (ev && (dn !== (k == T) || er !== e)) begin
            failures++;
            $display("FAIL R6 R9 %s %s beat %0d done=%0b err=%0b expected %0b %0b", rq, who, k, dn, er, (k == T), e);
        end
    endtask

    task automatic note(input bit ok, input string msg, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
        end
    endtask

    task automatic trial(input int nerr, input bit gaps, input bit abort_first, input string rq);
        int msg[N-NS];
        bit used[N];
        int pos, lim, k, acc, cnt;
        for (int j = 0; j < N; j++) begin word[j] = 0; used[j] = 1'b0; end
        for (int a = 0; a < N - NS; a++) msg[a] = $urandom_range(0, 255);
        for (int a = 0; a < N - NS; a++)
            for (int j = 0; j < NC; j++) word[a+j] ^= gmul(msg[a], gen[j]);
        for (int e = 0; e < nerr; e++) begin
            pos = $urandom_range(0, N - 1);
            while (used[pos]) pos = $urandom_range(0, N - 1);
            used[pos] = 1'b1;
            errpos[e] = pos;
            word[pos] ^= $urandom_range(1, 255);
        end
        for (int i = 0; i < NS; i++) begin
            acc = 0;
            for (int j = N - 1; j >= 0; j--) acc = gmul(acc, exp_t[i]) ^ word[j];
            syn[i] = acc;
        end
        mea(2 * T, na, ea, sa, oa);
        mea(LIMIT, nb, eb, sb, ob);
        for (int j = 0; j < NC; j++) begin cap_s[j] = -1; cap_o[j] = -1; end

        if (abort_first) begin   // R10: partial load discarded
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            for (int i = 0; i < 5; i++) begin
                syn_valid = 1'b1; syn_data = 8'($urandom_range(1, 255));
                @(negedge clk);
            end
            syn_valid = 1'b0;
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (gaps && (i % 3 == 1)) begin   // R2: idle beats ignored
                syn_valid = 1'b0; syn_data = 8'hA5;
                @(negedge clk);
            end
            syn_valid = 1'b1; syn_data = 8'(syn[i]);
            @(negedge clk);
        end
        syn_valid = 1'b0;
        syn_data = 8'h00;

        lim = ((na > nb) ? na : nb) + T + 4;
        for (int c = 0; c <= lim; c++) begin
            cmp("main", rq, ov_a, sg_a, om_a, dn_a, er_a, c, na, ea, sa, oa);
            cmp("capped", rq, ov_b, sg_b, om_b, dn_b, er_b, c, nb, eb, sb, ob);
            if (ov_a) begin
                k = c - na - 1;
                if (k >= 0 && k <= T) begin cap_s[k] = sg_a; cap_o[k] = om_a; end
            end
            if (ov_b && er_b) lim_err_seen = 1'b1;
            @(negedge clk);
        end
        for (int j = T + 1; j < NC; j++) begin cap_s[j] = 0; cap_o[j] = 0; end

        if (nerr == 0) begin
            // R8: sigma = 1, omega = 0
            acc = 0;
            for (int j = 0; j < NC; j++) acc += (cap_o[j] != 0) + ((j == 0) ? (cap_s[j] != 1) : (cap_s[j] != 0));
            note(acc == 0, "R8 zero-syndrome coefficient mismatches", acc, 0);
        end else begin
            // R7: roots at inverse error locations, degree and key equation
            for (int e = 0; e < nerr; e++)
                note(peval(cap_s, exp_t[(N - errpos[e]) % N]) == 0, "R7 sigma value at error root",
                     peval(cap_s, exp_t[(N - errpos[e]) % N]), 0);
            cnt = 0;
            for (int p = 0; p < N; p++) if (peval(cap_s, exp_t[(N - p) % N]) == 0) cnt++;
            note(cnt == nerr, "R7 root count", cnt, nerr);
            note(pdeg(cap_s) == nerr, "R7 sigma degree", pdeg(cap_s), nerr);
            cnt = 0;
            for (int i = 0; i < NS; i++) begin
                acc = 0;
                for (int j = 0; j <= i; j++) acc ^= gmul(syn[j], cap_s[i-j]);
                if (acc != ((i <= T) ? cap_o[i] : 0)) cnt++;
            end
            note(cnt == 0, "R7 key equation mismatching terms", cnt, 0);
        end
    endtask

    initial begin
        build_tables();
        make_gen();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        note(ov_a == 0 && dn_a == 0 && er_a == 0, "R1 main reset outputs", {ov_a, dn_a, er_a}, 0);
        note(ov_b == 0 && dn_b == 0 && er_b == 0, "R1 capped reset outputs", {ov_b, dn_b, er_b}, 0);
        trial(0, 1'b0, 1'b0, "R8");
        trial(1, 1'b0, 1'b0, "R3");
        trial(2, 1'b0, 1'b0, "R4");
        trial(4, 1'b1, 1'b0, "R2");
        trial(6, 1'b0, 1'b0, "R5");
        trial(T, 1'b0, 1'b0, "R7");
        trial(T, 1'b0, 1'b1, "R10");
        trial(3, 1'b1, 1'b1, "R6");
        for (int i = 0; i < 6; i++) trial($urandom_range(1, T), 1'b0, 1'b0, "R9");
        // R9: the capped instance must have raised its flag at least once
        note(lim_err_seen, "R9 capped instance error flag observed", lim_err_seen, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule